// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Guard for 32-bit Memory Words

This block sits between a host and a word-wide memory array. It protects each stored word with seven check bits. On the way in, it derives the check bits from the 32 data bits. On the way out, it examines the 39-bit word it is handed. A single flipped bit, whether in the data or in the check bits, is repaired. Two flipped bits are reported as unrecoverable and the word is passed on as it was read.

Both paths are valid/ready streams. The write path is a zero-latency pass-through: `wr_ready` simply follows `enc_ready`, and a write moves only on a cycle where both `wr_valid` and `wr_ready` are high. The read path registers its result. It accepts a word only when `rd_valid` and `rd_ready` are both high. The output holds steady for as long as `out_valid` is high and `out_ready` is low. Clean, uncorrectable and uncorrected words appear one cycle after they are accepted. A word that is actually repaired takes one extra stage, and during that stage the input is not ready.

Three plain control pins serve diagnostics. The first turns off repair. The second replaces the generated check bits with a value the host supplies. The raw stored check bits of every read are always returned alongside the data.

Top module: `ecc_guard`

## Requirements
- R1: The codeword has positions 1 to 38. Check bit i (i = 0..5) sits at position 2^i. Data bit 0 sits at position 3, and the remaining data bits fill the other non-power-of-two positions in ascending order. `enc_check[i]` is the XOR of all data bits whose position has bit i set. `enc_check[6]` makes the XOR of all 39 stored bits zero. `enc_valid` equals `wr_valid`, `wr_ready` equals `enc_ready`, and `enc_data` equals `wr_data`.
- R2: While `chk_force` is high, `enc_check` equals `chk_force_val` instead of the generated bits.
- R3: A word with no error appears with its data unchanged and both flags low, on the cycle after it is accepted.
- R4: A word with one flipped data bit, read with `corr_off` low, appears with the bit repaired and `out_single` high, two cycles after it is accepted.
- R5: A word with one flipped check bit (including `enc_check[6]`), read with `corr_off` low, appears with its data unchanged and `out_single` high, two cycles after it is accepted.
- R6: A word with two flipped bits appears with `out_double` high, `out_single` low and its data as read, one cycle after it is accepted.
- R7: With `corr_off` high at acceptance, a single-error word is returned unrepaired, with `out_single` high, one cycle after it is accepted.
- R8: `out_check` returns the check bits of the accepted word exactly as they were read.
- R9: While `out_valid` is high and `out_ready` is low, the output word and flags stay stable and `rd_ready` is low. On the cycle after a word needing repair is accepted, `rd_ready` is low. Results leave in acceptance order.
- R10: After reset, `out_valid` is low and `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_off | input | 1 | Diagnostic: return read data without repair |
| chk_force | input | 1 | Diagnostic: emit `chk_force_val` as check bits |
| chk_force_val | input | 7 | Host-chosen check bits |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | 32 | Write data |
| enc_valid | output | 1 | Encoded word offered to memory |
| enc_ready | input | 1 | Memory takes encoded word |
| enc_data | output | 32 | Data to store |
| enc_check | output | 7 | Check bits to store |
| rd_valid | input | 1 | Stored word offered for checking |
| rd_ready | output | 1 | Stored word taken |
| rd_data | input | 32 | Stored data bits |
| rd_check | input | 7 | Stored check bits |
| out_valid | output | 1 | Checked result offered |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 32 | Result data, repaired when applicable |
| out_check | output | 7 | Check bits as read |
| out_single | output | 1 | Single-bit error seen |
| out_double | output | 1 | Uncorrectable error seen |

## Verification
Encoder outputs are combinational, so they are compared a short delay after the inputs change within the same cycle. Each read is logged by the driver together with the cycle of its acceptance edge. The result is then due one cycle later for clean, double-error and repair-disabled words, and two cycles later for repaired words. The monitor compares the arrival cycle against that due cycle whenever the consumer has been ready throughout. In the back-pressure case only the contents are scored, and separate checks confirm that the result is held and that the input is not ready.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CHK_W  = PAR_W + 1;
  localparam int CODE_N = DATA_W + PAR_W;

  // codeword position of data bit k: k-th non-power-of-two value from 3 up
  function automatic int slot_of(input int k);
    int res;
    int cnt;
    res = 0;
    cnt = 0;
    for (int q = 3; q < 128; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == k && res == 0) res = q;
        cnt++;
      end
    end
    return res;
  endfunction

  // data bits covered by Hamming check bit i
  function automatic logic [DATA_W-1:0] cover_mask(input int i);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < DATA_W; k++) m[k] = ((slot_of(k) >> i) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [PAR_W-1:0] ham;

  always_comb begin
    for (int i = 0; i < PAR_W; i++) ham[i] = ^(data & cover_mask(i));
  end

  assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [PAR_W-1:0]  syn,
  output logic              single,
  output logic              double,
  output logic              any_err
);
  logic pmis;

  always_comb begin
    for (int i = 0; i < PAR_W; i++) syn[i] = chk[i] ^ (^(data & cover_mask(i)));
  end

  assign pmis    = ^{data, chk};
  assign any_err = pmis || (syn != '0);
  assign single  = pmis && (int'(syn) <= CODE_N);
  assign double  = any_err && !single;
endmodule

// File: rtl/ecc_fixer.sv
module ecc_fixer
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [PAR_W-1:0]  syn,
  output logic [DATA_W-1:0] fixed
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    localparam int SLOT = slot_of(k);
    assign fixed[k] = data[k] ^ (int'(syn) == SLOT);
  end
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              corr_off,
  input  logic              chk_force,
  input  logic [CHK_W-1:0]  chk_force_val,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enc_valid,
  input  logic              enc_ready,
  output logic [DATA_W-1:0] enc_data,
  output logic [CHK_W-1:0]  enc_check,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_check,
  output logic              out_single,
  output logic              out_double
);
  // write path: pure pass-through with check generation
  logic [CHK_W-1:0] gen_chk;

  ecc_encoder u_enc (.data(wr_data), .chk(gen_chk));

  assign enc_valid = wr_valid;
  assign wr_ready  = enc_ready;
  assign enc_data  = wr_data;
  assign enc_check = chk_force ? chk_force_val : gen_chk;

  // read path: classify on entry, repair in an optional extra stage
  logic [PAR_W-1:0] in_syn;
  logic             in_single, in_double, in_err;

  ecc_syndrome u_syn (
    .data(rd_data), .chk(rd_check), .syn(in_syn),
    .single(in_single), .double(in_double), .any_err(in_err)
  );

  logic              fix_v;
  logic [DATA_W-1:0] fix_data;
  logic [CHK_W-1:0]  fix_chk;
  logic [PAR_W-1:0]  fix_syn;
  logic [DATA_W-1:0] fix_out;

  ecc_fixer u_fix (.data(fix_data), .syn(fix_syn), .fixed(fix_out));

  logic adv, take, need_fix;
  assign adv      = !out_valid || out_ready;
  assign rd_ready = !fix_v && adv;
  assign take     = rd_valid && rd_ready;
  assign need_fix = in_single && !corr_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_v      <= 1'b0;
      fix_data   <= '0;
      fix_chk    <= '0;
      fix_syn    <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_check  <= '0;
      out_single <= 1'b0;
      out_double <= 1'b0;
    end else begin
      if (fix_v && adv) begin
        out_valid  <= 1'b1;
        out_data   <= fix_out;
        out_check  <= fix_chk;
        out_single <= 1'b1;
        out_double <= 1'b0;
        fix_v      <= 1'b0;
      end else if (take && !need_fix) begin
        out_valid  <= 1'b1;
        out_data   <= rd_data;
        out_check  <= rd_check;
        out_single <= in_single;
        out_double <= in_double;
      end else if (adv) begin
        out_valid  <= 1'b0;
      end
      if (take && need_fix) begin
        fix_v    <= 1'b1;
        fix_data <= rd_data;
        fix_chk  <= rd_check;
        fix_syn  <= in_syn;
      end
    end
  end

  // stored word built from fresh check bits must have even overall parity
  assert_enc_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !chk_force) |-> (^{wr_data, enc_check}) == 1'b0);

  assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_err) |=> (out_valid && !out_single && !out_double
                           && out_data == $past(rd_data)));

  assert_fix_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_single && !corr_off) |=> (!out_valid && !rd_ready) ##1 (out_valid && out_single));

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_single && out_double));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_single) && $stable(out_double)));
endmodule

// File: tb/ecc_guard_test.sv
module ecc_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        corr_off = 1'b0, chk_force = 1'b0;
  logic [6:0]  chk_force_val = '0;
  logic        wr_valid = 1'b0, enc_ready = 1'b1;
  logic [31:0] wr_data = '0;
  logic        wr_ready, enc_valid;
  logic [31:0] enc_data;
  logic [6:0]  enc_check;
  logic        rd_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] rd_data = '0;
  logic [6:0]  rd_check = '0;
  logic        rd_ready, out_valid, out_single, out_double;
  logic [31:0] out_data;
  logic [6:0]  out_check;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ecc_guard uut (.*);

  typedef struct {
    logic [31:0] d;
    logic [6:0]  c;
    bit          s;
    bit          dbl;
    int          due;
    bit          timed;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_chk(input logic [31:0] d);
    logic [38:0] w;
    logic [6:0]  c;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin w[p] = d[k]; k++; end
    for (int i = 0; i < 6; i++) begin
      c[i] = 1'b0;
      for (int p = 1; p <= 38; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) c[i] = c[i] ^ w[p];
    end
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  task automatic send(input logic [31:0] d, input logic [6:0] c, input bit off,
                      input logic [31:0] ed, input bit es, input bit edb,
                      input int lat, input bit timed, input string tag);
    item_t it;
    rd_valid = 1'b1; rd_data = d; rd_check = c; corr_off = off;
    while (!rd_ready) @(negedge clk);
    it.d = ed; it.c = c; it.s = es; it.dbl = edb;
    it.due = cyc + lat; it.timed = timed; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_valid = 1'b0; corr_off = 1'b0;
  endtask

  // monitor: score each result as it is handed over
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", {32'h0, out_data}, 64'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(out_data == it.d && out_single == it.s && out_double == it.dbl && out_check == it.c,
              {it.tag, " contents"},
              {out_single, out_double, 23'h0, out_check, out_data},
              {it.s, it.dbl, 23'h0, it.c, it.d});
        if (it.timed)
          check(cyc == it.due, {it.tag, " latency"}, 64'(cyc), 64'(it.due));
      end
    end
  end

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below 20000", cyc);
      finish_up();
    end
  end

  initial begin
    logic [31:0] vals [5];
    logic [6:0]  c;
    vals[0] = 32'h0000_0000; vals[1] = 32'hFFFF_FFFF; vals[2] = 32'hDEAD_BEEF;
    vals[3] = 32'h1234_5678; vals[4] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && rd_ready == 1'b1, "R10 reset state", {out_valid, rd_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // encoder
    foreach (vals[i]) begin
      wr_valid = 1'b1; wr_data = vals[i];
      #1;
      check(enc_check == ref_chk(vals[i]) && enc_data == vals[i] && enc_valid,
            "R1 encode", {enc_check, enc_data}, {ref_chk(vals[i]), vals[i]});
      @(negedge clk);
    end
    enc_ready = 1'b0; #1;
    check(wr_ready == 1'b0, "R1 ready follows", 64'(wr_ready), 64'd0);
    enc_ready = 1'b1;
    chk_force = 1'b1; chk_force_val = 7'h5A; #1;
    check(enc_check == 7'h5A, "R2 forced check", 64'(enc_check), 64'h5A);
    chk_force = 1'b0; wr_valid = 1'b0;
    @(negedge clk);

    // clean words, back to back
    foreach (vals[i]) send(vals[i], ref_chk(vals[i]), 1'b0, vals[i], 0, 0, 1, 1, "R3 R8 clean");

    // single data-bit errors
    c = ref_chk(vals[2]);
    send(vals[2] ^ 32'h1, c, 1'b0, vals[2], 1, 0, 2, 1, "R4 fix bit0");
    check(rd_ready == 1'b0, "R9 stall during repair", 64'(rd_ready), 64'd0);
    send(vals[3] ^ 32'h8000_0000, ref_chk(vals[3]), 1'b0, vals[3], 1, 0, 2, 1, "R4 fix bit31");
    send(vals[1] ^ 32'h0002_0000, ref_chk(vals[1]), 1'b0, vals[1], 1, 0, 2, 1, "R4 fix bit17");

    // single check-bit errors
    send(vals[2], c ^ 7'h01, 1'b0, vals[2], 1, 0, 2, 1, "R5 check bit0");
    send(vals[3], ref_chk(vals[3]) ^ 7'h20, 1'b0, vals[3], 1, 0, 2, 1, "R5 check bit5");
    send(vals[0], ref_chk(vals[0]) ^ 7'h40, 1'b0, vals[0], 1, 0, 2, 1, "R5 overall bit");

    // double errors
    send(vals[2] ^ 32'h0000_0208, c, 1'b0, vals[2] ^ 32'h0000_0208, 0, 1, 1, 1, "R6 two data");
    send(vals[4] ^ 32'h2, ref_chk(vals[4]) ^ 7'h04, 1'b0, vals[4] ^ 32'h2, 0, 1, 1, 1, "R6 data+check");

    // repair disabled
    send(vals[3] ^ 32'h0000_0400, ref_chk(vals[3]), 1'b1, vals[3] ^ 32'h0000_0400, 1, 0, 1, 1, "R7 no repair");

    // back-pressure
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    send(vals[2], c, 1'b0, vals[2], 0, 0, 1, 0, "R9 held word");
    repeat (3) @(negedge clk);
    check(out_valid && out_data == vals[2] && !rd_ready, "R9 held under stall",
          {out_valid, rd_ready, out_data}, {1'b1, 1'b0, vals[2]});
    @(posedge clk); #5;
    out_ready = 1'b1;

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R9 all results delivered", 64'(sb.size()), 64'd0);
    finish_up();
  end
endmodule